// File: doc/BRIEF.md
# Strided Phase-Offset Sine Table Fetch Unit

This block is one term generator of a multiplier-free tone synthesizer. A constant table holds exactly one period of a sine wave at the base frequency, in several pre-scaled copies ("banks") whose peak sizes are odd multiples of a common amplitude. On every clock the unit moves a read pointer forward by a programmable stride, wrapping inside the single period, so the samples it reads form a sinusoid at stride times the base frequency. Reading a larger stride gives a higher harmonic from the same table.

Scaling by a signed symbol value and choosing sine or cosine is done without arithmetic on the samples. The start point of the pointer is one of four quarter-period positions, picked from a sign flag and a sine/cosine flag. The bank is picked from a magnitude code. For example, a term equal to minus a symbol of value -3 times sine becomes a positive-sine fetch from the magnitude-3 bank. A load pulse captures the term set-up. The next cycles then stream the samples until the next load. Through a parameter, the sample output is either taken straight from the table read, which adds no latency, or taken through a flop for timing.

Top module: `ofs_fetch_unit`

## Requirements
- R1: After reset the pointer `index_o` is 0, the latched stride is 0, the latched bank is 0 and `sample_o` is 0.
- R2: On a clock edge with `load_i` high, the pointer becomes q·(TBL_LEN/4), where q = 2·`neg_i` + `cos_i`. This gives 0 for +sin, TBL_LEN/4 for +cos, TBL_LEN/2 for −sin and 3·TBL_LEN/4 for −cos.
- R3: On a clock edge with `load_i` low, the pointer advances by the stride captured at the last load.
- R4: When pointer plus stride reaches or passes TBL_LEN, TBL_LEN is subtracted, so the pointer stays below TBL_LEN. Strides of TBL_LEN/2 or more, up to TBL_LEN−1, are legal.
- R5: A captured stride of 0 holds the pointer fixed on every clock until the next load.
- R6: The sample for pointer i and magnitude code m is round(AMP·(2m+1)·sin(2π·i/TBL_LEN)), rounded half away from zero. Here AMP = floor((2^(SAMP_W−1)−1)/(2·NUM_BANKS−1)), which is 42 by default. The code m is the `mag_i` value captured at load and must be below NUM_BANKS.
- R7: With OUT_REG = 0, `sample_o` belongs to the current `index_o`. With OUT_REG = 1, `sample_o` is the sample of the pointer value one cycle earlier, and it is 0 straight after reset.
- R8: While `load_i` is low, changes on `stride_i`, `neg_i`, `cos_i` and `mag_i` have no effect on the pointer or the sample.
- R9: A load that arrives while the pointer is running restarts it from the new quarter offset, with the new stride and the new bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Capture the term set-up and restart the pointer |
| stride_i | input | IDX_W | Pointer step per clock; must be below TBL_LEN |
| neg_i | input | 1 | Term sign: 1 selects the negative half-period start |
| cos_i | input | 1 | 1 selects the cosine (quarter-period shifted) start |
| mag_i | input | MAG_W | Magnitude code m, selecting the bank with peak size 2m+1 |
| sample_o | output | SAMP_W | Signed fetched sample |
| index_o | output | IDX_W | Current table pointer |

## Verification
The assertions assume that `mag_i` holds a legal bank code whenever `load_i` is high. They also assume that reset is released before the first load. Given these, they expect the pointer to stay inside the table and to land on a quarter boundary after every load. The bench only loads magnitude codes 0 and 1 and strides below TBL_LEN. It drives the out-of-range `mag_i` value 3 only while `load_i` is low, to show that the input is ignored there. The bench runs a zero-latency instance and a registered instance side by side on the same stimulus and compares both against one rounded-sine model.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

   typedef enum logic [1:0] {
      Q_POS_SIN = 2'd0,
      Q_POS_COS = 2'd1,
      Q_NEG_SIN = 2'd2,
      Q_NEG_COS = 2'd3
   } quad_e;

   function automatic quad_e pick_quad(input logic neg, input logic cosine);
      return quad_e'({neg, cosine});
   endfunction

   localparam real TWO_PI = 6.28318530717958647692;

   function automatic int round_away(input real v);
      if (v >= 0.0) return $rtoi(v + 0.5);
      else          return -$rtoi(0.5 - v);
   endfunction

endpackage

// File: rtl/ofs_index_gen.sv
module ofs_index_gen
   import ofs_pkg::*;
#(
   parameter int TBL_LEN = 256,
   parameter int IDX_W   = $clog2(TBL_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  quad_e            quad_i,
   input  logic [IDX_W-1:0] stride_i,
   output logic [IDX_W-1:0] idx_o
);

   localparam int QTR = TBL_LEN / 4;

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] stride_q;
   logic [IDX_W-1:0] base;
   logic [IDX_W:0]   sum;
   logic [IDX_W-1:0] idx_next;

   always_comb begin
      base = IDX_W'(QTR * int'(quad_i));
      sum  = {1'b0, idx_q} + {1'b0, stride_q};
      if (sum >= (IDX_W+1)'(TBL_LEN)) idx_next = IDX_W'(sum - (IDX_W+1)'(TBL_LEN));
      else                            idx_next = sum[IDX_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q    <= '0;
         stride_q <= '0;
      end else if (load_i) begin
         idx_q    <= base;
         stride_q <= stride_i;
      end else begin
         idx_q    <= idx_next;
      end
   end

   assign idx_o = idx_q;

   // R4: the pointer never leaves the single period
   assert_index_in_range_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      int'(idx_q) < TBL_LEN);

   // R2: a load always lands on a quarter-period boundary
   assert_load_on_quarter_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (int'(idx_q) % QTR) == 0);

   // R5: a zero stride freezes the pointer between loads
   assert_zero_stride_hold_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && stride_q == '0) |=> $stable(idx_q));

   // R8: the captured stride only moves on a load
   assert_stride_kept_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(stride_q));

endmodule

// File: rtl/ofs_sine_rom.sv
module ofs_sine_rom
   import ofs_pkg::*;
#(
   parameter int TBL_LEN   = 256,
   parameter int SAMP_W    = 8,
   parameter int NUM_BANKS = 2,
   parameter int IDX_W     = $clog2(TBL_LEN),
   parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic [IDX_W-1:0]         idx_i,
   input  logic [BANK_W-1:0]        bank_i,
   output logic signed [SAMP_W-1:0] sample_o
);

   localparam int AMP = (2**(SAMP_W-1) - 1) / (2*NUM_BANKS - 1);

   function automatic int entry(input int b, input int i);
      real ang;
      ang = TWO_PI * real'(i) / real'(TBL_LEN);
      return round_away(real'(AMP * (2*b + 1)) * $sin(ang));
   endfunction

   logic signed [SAMP_W-1:0] rom [NUM_BANKS][TBL_LEN];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      for (genvar i = 0; i < TBL_LEN; i++) begin : g_ent
         localparam logic signed [SAMP_W-1:0] VAL = SAMP_W'(entry(b, i));
         assign rom[b][i] = VAL;
      end
   end

   assign sample_o = rom[bank_i][idx_i];

endmodule

// File: rtl/ofs_fetch_unit.sv
module ofs_fetch_unit
   import ofs_pkg::*;
#(
   parameter int TBL_LEN   = 256,
   parameter int SAMP_W    = 8,
   parameter int NUM_BANKS = 2,
   parameter int MAG_W     = 2,
   parameter bit OUT_REG   = 1'b0,
   parameter int IDX_W     = $clog2(TBL_LEN)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load_i,
   input  logic [IDX_W-1:0]         stride_i,
   input  logic                     neg_i,
   input  logic                     cos_i,
   input  logic [MAG_W-1:0]         mag_i,
   output logic signed [SAMP_W-1:0] sample_o,
   output logic [IDX_W-1:0]         index_o
);

   localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

   if (TBL_LEN % 4 != 0 || TBL_LEN < 8) begin : g_bad_len
      $error("TBL_LEN must be a multiple of 4 and at least 8");
   end
   if (NUM_BANKS < 1 || NUM_BANKS > 2**MAG_W || MAG_W < BANK_W) begin : g_bad_banks
      $error("NUM_BANKS must fit the magnitude code width");
   end
   if ((2**(SAMP_W-1) - 1) / (2*NUM_BANKS - 1) < 1) begin : g_bad_width
      $error("SAMP_W too small for the largest bank");
   end

   logic [IDX_W-1:0]         idx;
   logic [BANK_W-1:0]        bank_q;
   logic signed [SAMP_W-1:0] rom_sample;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bank_q <= '0;
      else if (load_i) bank_q <= mag_i[BANK_W-1:0];
   end

   ofs_index_gen #(.TBL_LEN(TBL_LEN), .IDX_W(IDX_W)) u_index (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_i),
      .quad_i   (pick_quad(neg_i, cos_i)),
      .stride_i (stride_i),
      .idx_o    (idx)
   );

   ofs_sine_rom #(
      .TBL_LEN(TBL_LEN), .SAMP_W(SAMP_W), .NUM_BANKS(NUM_BANKS),
      .IDX_W(IDX_W), .BANK_W(BANK_W)
   ) u_rom (
      .idx_i    (idx),
      .bank_i   (bank_q),
      .sample_o (rom_sample)
   );

   if (OUT_REG) begin : g_out_reg
      logic signed [SAMP_W-1:0] sample_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sample_q <= '0;
         else        sample_q <= rom_sample;
      end
      assign sample_o = sample_q;
   end else begin : g_out_comb
      assign sample_o = rom_sample;
   end

   assign index_o = idx;

   // R6: only legal magnitude codes are captured
   assert_mag_legal_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> int'(mag_i) < NUM_BANKS);

   // R6: sine zero crossings read zero from every bank
   assert_zero_cross_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (int'(idx) == 0 || int'(idx) == TBL_LEN/2) |-> rom_sample == '0);

endmodule

// File: tb/test_ofs_fetch_unit.sv
module test_ofs_fetch_unit;

   localparam int  CLK_PERIOD = 10;
   localparam int  NM   = 256;
   localparam int  AMP  = 42;
   localparam real TPI  = 6.28318530717958647692;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             load_i = 1'b0;
   logic [7:0]       stride_i = '0;
   logic             neg_i = 1'b0;
   logic             cos_i = 1'b0;
   logic [1:0]       mag_i = '0;
   logic signed [7:0] samp_c, samp_r;
   logic [7:0]       idx_c, idx_r;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   int m_idx = 0, m_st = 0, m_mag = 0, m_reg = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ofs_fetch_unit i_ofs_fetch_unit (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .stride_i(stride_i),
      .neg_i(neg_i), .cos_i(cos_i), .mag_i(mag_i),
      .sample_o(samp_c), .index_o(idx_c));

   ofs_fetch_unit #(.OUT_REG(1'b1)) i_ofs_fetch_unit_reg (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .stride_i(stride_i),
      .neg_i(neg_i), .cos_i(cos_i), .mag_i(mag_i),
      .sample_o(samp_r), .index_o(idx_r));

   function automatic int exp_samp(input int m, input int i);
      real v;
      v = real'(AMP * (2*m + 1)) * $sin(TPI * real'(i) / real'(NM));
      if (v >= 0.0) return $rtoi(v + 0.5);
      else          return -$rtoi(0.5 - v);
   endfunction

   task automatic chk(input string tag, input int got, input int exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk(tag, int'(idx_c), m_idx);
      chk(tag, int'(samp_c), exp_samp(m_mag, m_idx));
      chk("R7", int'(samp_r), m_reg);
   endtask

   // one clock: inputs applied, edge, model update
   task automatic tick(input logic ld, input int st, input logic ng,
                       input logic cs, input int mg);
      load_i = ld; stride_i = 8'(st); neg_i = ng; cos_i = cs; mag_i = 2'(mg);
      @(posedge clk);
      #1;
      m_reg = exp_samp(m_mag, m_idx);
      if (ld) begin
         m_idx = (2*int'(ng) + int'(cs)) * (NM/4);
         m_st  = st;
         m_mag = mg;
      end else begin
         m_idx = m_idx + m_st;
         if (m_idx >= NM) m_idx = m_idx - NM;
      end
      load_i = 1'b0;
   endtask

   task automatic t_reset;
      #1;
      chk("R1", int'(idx_c), 0);
      chk("R1", int'(samp_c), 0);
      chk("R1", int'(samp_r), 0);
      rst_n = 1'b1;
      tick(1'b0, 0, 1'b0, 1'b0, 0);
      check_all("R1");
   endtask

   task automatic t_quadrants;
      for (int q = 0; q < 4; q++) begin
         tick(1'b1, 1, q[1], q[0], 0);
         chk("R2", int'(idx_c), q * (NM/4));
         check_all("R2");
         tick(1'b0, 0, 1'b0, 1'b0, 0);
         check_all("R2");
      end
   endtask

   task automatic t_stride;
      tick(1'b1, 5, 1'b0, 1'b1, 0);
      for (int c = 0; c < 40; c++) begin
         tick(1'b0, 5, 1'b0, 1'b1, 0);
         check_all("R3");
      end
   endtask

   task automatic t_wrap;
      tick(1'b1, 200, 1'b1, 1'b1, 1);
      for (int c = 0; c < 12; c++) begin
         tick(1'b0, 200, 1'b1, 1'b1, 1);
         check_all("R4");
      end
      tick(1'b1, 255, 1'b0, 1'b0, 0);
      tick(1'b0, 0, 1'b0, 1'b0, 0);
      chk("R4", int'(idx_c), 255);
      check_all("R4");
   endtask

   task automatic t_hold;
      tick(1'b1, 0, 1'b0, 1'b1, 1);
      for (int c = 0; c < 8; c++) begin
         tick(1'b0, 0, 1'b0, 1'b1, 1);
         chk("R5", int'(idx_c), NM/4);
         check_all("R5");
      end
   endtask

   task automatic t_banks;
      for (int m = 0; m < 2; m++) begin
         tick(1'b1, 7, 1'b1, 1'b0, m);
         check_all("R6");
         for (int c = 0; c < 40; c++) begin
            tick(1'b0, 7, 1'b1, 1'b0, m);
            check_all("R6");
         end
      end
      tick(1'b1, 0, 1'b0, 1'b1, 1);
      chk("R6", int'(samp_c), 126);
   endtask

   task automatic t_ignored;
      tick(1'b1, 3, 1'b0, 1'b0, 0);
      for (int c = 0; c < 10; c++) begin
         tick(1'b0, 77 + c, c[0], c[1], 3 - (c % 2) * 2);
         check_all("R8");
      end
   endtask

   task automatic t_restart;
      tick(1'b1, 9, 1'b0, 1'b0, 0);
      for (int c = 0; c < 6; c++) tick(1'b0, 9, 1'b0, 1'b0, 0);
      tick(1'b1, 11, 1'b1, 1'b0, 1);
      chk("R9", int'(idx_c), NM/2);
      check_all("R9");
      for (int c = 0; c < 6; c++) begin
         tick(1'b0, 11, 1'b1, 1'b0, 1);
         check_all("R9");
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_quadrants();
      t_stride();
      t_wrap();
      t_hold();
      t_banks();
      t_ignored();
      t_restart();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule